// File: doc/BRIEF.md
# Write-Start Qualifier with Supply Lockout

This block sits between the control pins of a byte-wide non-volatile memory interface and the logic that runs an internal program cycle. It decides whether a falling write strobe may start a write cycle. When it may, it emits a single-cycle start pulse. The pins it watches are chip-enable, output-enable and write-enable, all active low, together with a digital flag that reports the supply is above its sense threshold.

Every pin first passes through a synchronizer chain. A write window is the span in which chip-enable and write-enable are both low while output-enable is high. Which strobe falls second does not matter, so both write-enable-led and chip-enable-led writes are accepted. A window only counts once it has lasted a minimum number of clock cycles, which rejects short glitches on either strobe.

Writes are locked out while the supply flag is low. They stay locked out for a power-on delay after the flag comes back, and any dip of the flag restarts that delay from zero. The delay, the filter width and the synchronizer depth are parameters counted in clock cycles.

Top module: `wr_inhibit_qual`

## Requirements
- R1: While reset is asserted and right after it is released, `wr_start` is 0.
- R2: While the synchronized supply flag is low, no write start is issued, whatever the strobes do.
- R3: After the supply flag rises, writes are locked out for POR_CYCLES clock cycles of continuous supply-good. A window that completes later than that yields a start pulse.
- R4: If the supply flag drops at any time, the power-on count returns to zero and the full delay is served again after the flag returns.
- R5: Output-enable held low (0) blocks a write start even when both strobes are low.
- R6: Chip-enable high (1) with write-enable pulsing, or write-enable high (1) with chip-enable pulsing, produces no write start.
- R7: A write window shorter than FILT_CYCLES clock cycles gives no start pulse. A window of exactly FILT_CYCLES cycles gives one.
- R8: A write is accepted both when write-enable falls while chip-enable is already low and when chip-enable falls while write-enable is already low.
- R9: The start pulse is high for exactly one clock cycle and occurs once per window. It goes high after the (SYNC_STAGES+FILT_CYCLES)-th rising clock edge following the fall of the later strobe.
- R10: A window that reaches the filter width while writes are locked out produces no pulse, even if it is still open when the lockout ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-above-threshold flag, asynchronous |
| ce_n | input | 1 | Chip-enable pin, active low, asynchronous |
| oe_n | input | 1 | Output-enable pin, active low, asynchronous |
| we_n | input | 1 | Write-enable pin, active low, asynchronous |
| wr_start | output | 1 | One-cycle qualified write-start pulse |

## Verification
The glitch filter and the power-on lockout can both reach their limits in the same cycle: a strobe window that completes its filter count while the lockout is still running must not fire once the lockout expires. The bench provokes this by opening a window a couple of cycles after the supply flag returns and holding it well past the end of the delay. It judges the case by counting start pulses over the whole window and expecting none. A fresh window is then opened to show the block is armed.

// File: rtl/wiq_pkg.sv
package wiq_pkg;
   // Bundle of asynchronous inputs carried through the synchronizer together.
   typedef struct packed {
      logic sup_ok;
      logic ce_n;
      logic oe_n;
      logic we_n;
   } pin_set_t;

   // Values the synchronized pins take in reset: supply not good, all strobes idle.
   localparam pin_set_t PINS_IDLE = '{sup_ok: 1'b0, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};
endpackage

// File: rtl/wiq_sync.sv
module wiq_sync #(
   parameter int               WIDTH   = 4,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wiq_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("wiq_sync: WIDTH must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/wiq_por_timer.sv
module wiq_por_timer #(
   parameter int POR_CYCLES = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_ok,
   output logic ready
);
   localparam int CW = $clog2(POR_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(POR_CYCLES);

   if (POR_CYCLES < 1) begin : g_bad_por
      $error("wiq_por_timer: POR_CYCLES must be at least 1");
   end

   logic [CW-1:0] good_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                good_cnt <= '0;
      else if (!sup_ok)          good_cnt <= '0;
      else if (good_cnt != LIMIT) good_cnt <= good_cnt + 1'b1;
   end

   assign ready = (good_cnt == LIMIT);

   // R4
   re_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_ok |=> !ready);
   // R3
   ready_needs_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(sup_ok));
endmodule

// File: rtl/wiq_strobe_filter.sv
module wiq_strobe_filter #(
   parameter int FILT_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic window,
   output logic hit
);
   if (FILT_CYCLES < 1) begin : g_bad_filt
      $error("wiq_strobe_filter: FILT_CYCLES must be at least 1");
   end

   if (FILT_CYCLES == 1) begin : g_edge
      // No width to wait for: fire on the first cycle of a window.
      logic window_d;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) window_d <= 1'b0;
         else        window_d <= window;
      end
      assign hit = window & ~window_d;
   end else begin : g_count
      localparam int FW = $clog2(FILT_CYCLES + 1);
      localparam logic [FW-1:0] FMAX = FW'(FILT_CYCLES);
      localparam logic [FW-1:0] FHIT = FW'(FILT_CYCLES - 1);
      logic [FW-1:0] run_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              run_cnt <= '0;
         else if (!window)        run_cnt <= '0;
         else if (run_cnt != FMAX) run_cnt <= run_cnt + 1'b1;
      end
      assign hit = window & (run_cnt == FHIT);
   end

   // R9
   one_hit_per_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);
endmodule

// File: rtl/wr_inhibit_qual.sv
module wr_inhibit_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int POR_CYCLES  = 250000,
   parameter int FILT_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   output logic wr_start
);
   import wiq_pkg::*;

   localparam int PW = $bits(pin_set_t);
   localparam int RW = $clog2(FILT_CYCLES + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wr_inhibit_qual: SYNC_STAGES must be at least 2");
   end

   pin_set_t raw_pins, syn_pins;
   logic     window, hit, armed;

   assign raw_pins = '{sup_ok: supply_ok, ce_n: ce_n, oe_n: oe_n, we_n: we_n};

   wiq_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_pins), .q(syn_pins)
   );

   // Write window: both enables low with output-enable high.
   assign window = ~syn_pins.ce_n & ~syn_pins.we_n & syn_pins.oe_n;

   wiq_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
      .clk(clk), .rst_n(rst_n), .sup_ok(syn_pins.sup_ok), .ready(armed)
   );

   wiq_strobe_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk(clk), .rst_n(rst_n), .window(window), .hit(hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_start <= 1'b0;
      else        wr_start <= hit & armed & syn_pins.sup_ok;
   end

   // Checker counter: consecutive window cycles, saturating at the filter width.
   logic [RW-1:0] chk_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           chk_run <= '0;
      else if (!window)                     chk_run <= '0;
      else if (chk_run != RW'(FILT_CYCLES)) chk_run <= chk_run + 1'b1;
   end

   // R2
   supply_low_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !syn_pins.sup_ok |=> !wr_start);
   // R3
   lockout_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |-> $past(armed));
   // R5
   oe_low_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !syn_pins.oe_n |=> !wr_start);
   // R6
   enable_high_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (syn_pins.ce_n || syn_pins.we_n) |=> !wr_start);
   // R7
   min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |-> ($past(window) && $past(chk_run) == RW'(FILT_CYCLES - 1)));
   // R9
   single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> !wr_start);
endmodule

// File: tb/tb_wr_inhibit_qual.sv
module tb_wr_inhibit_qual;
   localparam int SYNC = 2;
   localparam int POR  = 40;
   localparam int FILT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sup = 1'b0, ce = 1'b1, oe = 1'b1, we = 1'b1;
   logic wr_start;

   int checks = 0, failures = 0, pulses = 0, doubles = 0;
   logic prev_ws = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wr_inhibit_qual #(.SYNC_STAGES(SYNC), .POR_CYCLES(POR), .FILT_CYCLES(FILT)) dut (
      .clk(clk), .rst_n(rst_n), .supply_ok(sup), .ce_n(ce), .oe_n(oe), .we_n(we),
      .wr_start(wr_start)
   );

   always @(negedge clk) begin
      if (wr_start === 1'b1) pulses++;
      if (wr_start === 1'b1 && prev_ws === 1'b1) doubles++;
      prev_ws = wr_start;
   end

   task automatic check_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe_we(input int len);
      @(negedge clk); ce = 1'b0; idle(2);
      we = 1'b0; idle(len); we = 1'b1;
      idle(1); ce = 1'b1; idle(8);
   endtask

   task automatic strobe_ce(input int len);
      @(negedge clk); we = 1'b0; idle(2);
      ce = 1'b0; idle(len); ce = 1'b1;
      idle(1); we = 1'b1; idle(8);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; idle(3);
      check_eq("R1 during reset", int'(wr_start), 0);
      rst_n = 1'b1; idle(5);
      check_eq("R1 after release", pulses, 0);
   endtask

   task automatic t_supply_low;
      int p0 = pulses;
      sup = 1'b0;
      strobe_we(10);
      strobe_ce(10);
      check_eq("R2 supply low", pulses - p0, 0);
   endtask

   task automatic t_power_on;
      int p0 = pulses;
      @(negedge clk); sup = 1'b1;
      strobe_we(5);
      check_eq("R3 inside delay", pulses - p0, 0);
      idle(POR + 5);
      p0 = pulses;
      strobe_we(5);
      check_eq("R3 after delay", pulses - p0, 1);
   endtask

   task automatic t_latency;
      int p0 = pulses;
      int d0 = doubles;
      @(negedge clk); ce = 1'b0; idle(3);
      we = 1'b0;
      repeat (SYNC + FILT) @(posedge clk);
      @(negedge clk);
      check_eq("R9 pulse cycle", int'(wr_start), 1);
      @(negedge clk);
      check_eq("R9 pulse ends", int'(wr_start), 0);
      idle(4); we = 1'b1; idle(1); ce = 1'b1; idle(8);
      check_eq("R8 we-led write", pulses - p0, 1);
      check_eq("R9 width", doubles - d0, 0);
   endtask

   task automatic t_ce_led;
      int p0 = pulses;
      strobe_ce(6);
      check_eq("R8 ce-led write", pulses - p0, 1);
   endtask

   task automatic t_filter;
      int p0 = pulses;
      strobe_we(FILT - 1);
      strobe_ce(1);
      check_eq("R7 short window", pulses - p0, 0);
      p0 = pulses;
      strobe_we(FILT);
      check_eq("R7 exact window", pulses - p0, 1);
   endtask

   task automatic t_oe_low;
      int p0 = pulses;
      @(negedge clk); oe = 1'b0;
      strobe_we(8);
      strobe_ce(8);
      oe = 1'b1; idle(4);
      check_eq("R5 oe low", pulses - p0, 0);
   endtask

   task automatic t_enable_high;
      int p0 = pulses;
      @(negedge clk); we = 1'b0; idle(8); we = 1'b1; idle(6);
      check_eq("R6 ce high", pulses - p0, 0);
      p0 = pulses;
      @(negedge clk); ce = 1'b0; idle(8); ce = 1'b1; idle(6);
      check_eq("R6 we high", pulses - p0, 0);
   endtask

   task automatic t_drop;
      int p0 = pulses;
      @(negedge clk); sup = 1'b0; idle(3); sup = 1'b1;
      strobe_we(5);
      check_eq("R4 re-armed lockout", pulses - p0, 0);
      idle(POR + 5);
      p0 = pulses;
      strobe_we(5);
      check_eq("R4 delay served", pulses - p0, 1);
   endtask

   task automatic t_hold_through;
      int p0 = pulses;
      @(negedge clk); sup = 1'b0; idle(3); sup = 1'b1; idle(2);
      ce = 1'b0; we = 1'b0;
      idle(POR + 20);
      we = 1'b1; ce = 1'b1; idle(8);
      check_eq("R10 window held across lockout end", pulses - p0, 0);
      p0 = pulses;
      strobe_ce(4);
      check_eq("R10 fresh window after", pulses - p0, 1);
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      t_reset();
      t_supply_low();
      t_power_on();
      t_latency();
      t_ce_led();
      t_filter();
      t_oe_low();
      t_enable_high();
      t_drop();
      t_hold_through();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog all-requirements actual=timeout expected=completion");
         summary();
         $finish;
      end
   end
endmodule